// File: doc/BRIEF.md
# Address-Phase Arbiter with Early Push-Pull Switch

This block drives the seven address bits that follow a START on a two-wire serial bus and watches the shared data line while it does. The data line is open-drain during arbitration, so a low from any device beats a high. The arbiter shifts its address out most significant bit first. It changes SDA on each falling SCL edge and compares the line on each rising edge. If it drives a 1 and reads back a 0, it has lost. It then releases the line and takes no further part until the next transaction begins. If all seven bits pass, it reports a win. The lower address always wins, and the contest is over by the end of the address.

When the address being sent is the broadcast address 0x7E, the block also decides how early in the byte it may turn SDA into a push-pull driver. At the START it captures the highest dynamic address currently assigned. Push-pull drive starts after the first bit count k whose leading bits of 0x7E, with the remaining bits taken as zero, already exceed that highest address. At that point no assigned target can still be contending. If no such k exists below seven, the whole address stays open-drain.

An address sent after a repeated START is never contested. It is shifted out with the same drive-mode rule, but without any comparison.

Top module: `arb_addr_phase`

## Requirements
- R1: After reset, `sda_o` is 1 (released), `sda_pp` is 0, and neither `arb_lost` nor `arb_won` is asserted.
- R2: One clock after `txn_start` or an accepted `rstart`, `sda_o` is 0 (holding the START). Address bit 6 is driven on the first falling SCL edge, bit 5 on the next, and so on down to bit 0.
- R3: When the block is contesting in open-drain mode and drives 1 but samples `sda_i` = 0 at a rising SCL edge, `arb_lost` pulses high for exactly one clock.
- R4: After a loss, `sda_o` stays 1 and `sda_pp` stays 0, with no further pulses. A `rstart` in this state is ignored. Only `txn_start` resumes operation.
- R5: If no loss occurs, `arb_won` pulses for exactly one clock after the rising SCL edge of the seventh bit. `sda_o` then returns to 1 and `sda_pp` to 0.
- R6: `sda_pp` rises only when the captured address equals 0x7E. It rises at the rising SCL edge that completes bit count k, where k (1..6) is the smallest count whose prefix value (the top k bits of 0x7E with zeros below) is greater than the highest dynamic address.
- R7: If no such k exists (highest address 0x7E or 0x7F), `sda_pp` stays 0 for the whole address.
- R8: After `rstart`, no comparison is made and `arb_lost` never pulses, even when the bus is pulled low under a driven 1. `arb_won` follows the seventh bit, and R6 still applies.
- R9: `tx_addr` and `hi_dyn_addr` are captured on the start pulse. Later changes have no effect on the current address phase.
- R10: `arb_lost` and `arb_won` are never high together, and a loss is never reported while `sda_pp` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_start | input | 1 | Pulse: START seen, begin a contested address phase |
| rstart | input | 1 | Pulse: repeated START, send address without contest |
| tx_addr | input | 7 | Address to send |
| hi_dyn_addr | input | 7 | Highest dynamic address currently assigned |
| scl_i | input | 1 | Synchronized SCL sample |
| sda_i | input | 1 | Synchronized SDA sample |
| sda_o | output | 1 | SDA drive value (1 = release in open-drain mode) |
| sda_pp | output | 1 | 1 = drive SDA push-pull, 0 = open-drain |
| arb_lost | output | 1 | One-clock pulse: arbitration lost |
| arb_won | output | 1 | One-clock pulse: address sent without loss |

## Verification
The bench models a rival device on the wired-AND line. The rival backs off the way a real contender does, so losses on the first bit, a middle bit and the last bit are all exercised. A design that compared on the wrong edge, or kept driving after a loss, would show a wrong `sda_o` on the following bits. The switch point is exercised at k = 1, 2, 3 and 6 and at the no-switch boundary. An off-by-one in the prefix comparison would move `sda_pp` one bit early or late. A loss on the same edge where push-pull would have begun must keep the line open-drain. The bench also checks that a repeated START after a loss changes nothing, and that a repeated START on a driven-low bus never reports a loss. It changes both address inputs mid-phase to catch a design that reads them live rather than capturing them.

// File: rtl/arb_addr_pkg.sv
package arb_addr_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_RUN  = 2'd1,
      PH_LOST = 2'd2,
      PH_DONE = 2'd3
   } phase_t;

endpackage

// File: rtl/arb_addr_scl_edge.sv
module arb_addr_scl_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   output logic scl_rise,
   output logic scl_fall
);
   logic scl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scl_q <= 1'b1;
      else        scl_q <= scl_i;
   end

   assign scl_rise = scl_i & ~scl_q;
   assign scl_fall = ~scl_i & scl_q;
endmodule

// File: rtl/arb_addr_switch_pt.sv
module arb_addr_switch_pt #(
   parameter int unsigned          ADDR_W     = 7,
   parameter logic [ADDR_W-1:0]    BCAST_ADDR = 7'h7E,
   parameter bit                   EARLY_PP   = 1'b1,
   localparam int unsigned         IDX_W      = $clog2(ADDR_W + 1)
) (
   input  logic [ADDR_W-1:0] hi_addr,
   output logic [IDX_W-1:0]  sw_idx,
   output logic              sw_valid
);
   logic [ADDR_W-1:0] fits;

   assign fits[0] = 1'b0;

   generate
      if (EARLY_PP) begin : g_early
         for (genvar k = 1; k < ADDR_W; k++) begin : g_k
            localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << (ADDR_W - k)) - 1);
            localparam logic [ADDR_W-1:0] PREFIX   = BCAST_ADDR & ~LOW_MASK;
            assign fits[k] = (PREFIX > hi_addr);
         end
      end else begin : g_late
         assign fits[ADDR_W-1:1] = '0;
      end
   endgenerate

   always_comb begin
      sw_valid = 1'b0;
      sw_idx   = '0;
      for (int k = ADDR_W - 1; k >= 1; k--) begin
         if (fits[k]) begin
            sw_valid = 1'b1;
            sw_idx   = IDX_W'(k);
         end
      end
   end
endmodule

// File: rtl/arb_addr_bitseq.sv
module arb_addr_bitseq
   import arb_addr_pkg::*;
#(
   parameter int unsigned  ADDR_W = 7,
   localparam int unsigned IDX_W  = $clog2(ADDR_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              txn_start,
   input  logic              rstart,
   input  logic [ADDR_W-1:0] tx_addr,
   input  logic              is_bcast,
   input  logic [IDX_W-1:0]  sw_idx,
   input  logic              sw_valid,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_i,
   output logic              sda_o,
   output logic              sda_pp,
   output logic              arb_lost,
   output logic              arb_won
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_W - 1);

   phase_t            phase;
   logic [IDX_W-1:0]  idx;
   logic [ADDR_W-1:0] addr_q;
   logic              contest;
   logic              bc_q;
   logic [IDX_W-1:0]  swi_q;
   logic              swv_q;
   logic [IDX_W-1:0]  idx_nxt;
   logic [IDX_W-1:0]  bit_pos;
   logic              go;

   assign idx_nxt = idx + 1'b1;
   assign bit_pos = LAST_IDX - idx;
   assign go      = txn_start || (rstart && phase != PH_LOST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         idx      <= '0;
         addr_q   <= '0;
         contest  <= 1'b0;
         bc_q     <= 1'b0;
         swi_q    <= '0;
         swv_q    <= 1'b0;
         sda_o    <= 1'b1;
         sda_pp   <= 1'b0;
         arb_lost <= 1'b0;
         arb_won  <= 1'b0;
      end else begin
         arb_lost <= 1'b0;
         arb_won  <= 1'b0;
         if (go) begin
            phase   <= PH_RUN;
            idx     <= '0;
            addr_q  <= tx_addr;
            contest <= txn_start;
            bc_q    <= is_bcast;
            swi_q   <= sw_idx;
            swv_q   <= sw_valid;
            sda_o   <= 1'b0;
            sda_pp  <= 1'b0;
         end else if (phase == PH_RUN) begin
            if (scl_fall) begin
               sda_o <= addr_q[bit_pos];
            end else if (scl_rise) begin
               if (contest && !sda_pp && sda_o && !sda_i) begin
                  arb_lost <= 1'b1;
                  phase    <= PH_LOST;
                  sda_o    <= 1'b1;
               end else if (idx == LAST_IDX) begin
                  arb_won <= 1'b1;
                  phase   <= PH_DONE;
                  sda_o   <= 1'b1;
                  sda_pp  <= 1'b0;
               end else begin
                  idx <= idx_nxt;
                  if (bc_q && swv_q && idx_nxt == swi_q) sda_pp <= 1'b1;
               end
            end
         end
      end
   end

   AST_LOST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      arb_lost |=> !arb_lost);                                   // R3
   AST_WON_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      arb_won |=> !arb_won);                                     // R5
   AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(arb_lost && arb_won));                                   // R10
   AST_NO_LOSS_IN_PP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arb_lost) |-> !$past(sda_pp));                       // R10
   AST_RELEASE_AFTER_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_LOST) |-> (sda_o && !sda_pp));                // R4
   AST_PP_ONLY_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
      sda_pp |-> bc_q);                                          // R6
   AST_PP_DROP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_pp) |-> (arb_won || $past(txn_start) || $past(rstart))); // R6
   AST_NO_LOSS_UNCONTESTED: assert property (@(posedge clk) disable iff (!rst_n)
      arb_lost |-> contest);                                     // R8
endmodule

// File: rtl/arb_addr_phase.sv
module arb_addr_phase #(
   parameter int unsigned       ADDR_W     = 7,
   parameter logic [ADDR_W-1:0] BCAST_ADDR = 7'h7E,
   parameter bit                EARLY_PP   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              txn_start,
   input  logic              rstart,
   input  logic [ADDR_W-1:0] tx_addr,
   input  logic [ADDR_W-1:0] hi_dyn_addr,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_o,
   output logic              sda_pp,
   output logic              arb_lost,
   output logic              arb_won
);
   localparam int unsigned IDX_W = $clog2(ADDR_W + 1);

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("arb_addr_phase: ADDR_W must be at least 2");
      end
      if (BCAST_ADDR[ADDR_W-1] != 1'b1) begin : g_bad_bcast
         $error("arb_addr_phase: broadcast address must have its top bit set");
      end
   endgenerate

   logic             scl_rise;
   logic             scl_fall;
   logic [IDX_W-1:0] sw_idx;
   logic             sw_valid;
   logic             is_bcast;

   assign is_bcast = (tx_addr == BCAST_ADDR);

   arb_addr_scl_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall)
   );

   arb_addr_switch_pt #(
      .ADDR_W     (ADDR_W),
      .BCAST_ADDR (BCAST_ADDR),
      .EARLY_PP   (EARLY_PP)
   ) u_switch (
      .hi_addr  (hi_dyn_addr),
      .sw_idx   (sw_idx),
      .sw_valid (sw_valid)
   );

   arb_addr_bitseq #(
      .ADDR_W (ADDR_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .txn_start (txn_start),
      .rstart    (rstart),
      .tx_addr   (tx_addr),
      .is_bcast  (is_bcast),
      .sw_idx    (sw_idx),
      .sw_valid  (sw_valid),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .sda_i     (sda_i),
      .sda_o     (sda_o),
      .sda_pp    (sda_pp),
      .arb_lost  (arb_lost),
      .arb_won   (arb_won)
   );
endmodule

// File: tb/arb_addr_phase_bench.sv
module arb_addr_phase_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       txn_start = 1'b0;
   logic       rstart = 1'b0;
   logic [6:0] tx_addr = 7'h00;
   logic [6:0] hi_addr = 7'h00;
   logic       scl = 1'b1;
   logic       rival_drv = 1'b1;
   logic       sda_bus;
   logic       sda_o, sda_pp, lost, won;
   int         n_tests = 0;
   int         n_fail = 0;
   bit         finished = 1'b0;

   always #2 clk = ~clk;

   assign sda_bus = sda_pp ? sda_o : (sda_o & rival_drv);

   arb_addr_phase u_arb_addr_phase (
      .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .rstart(rstart),
      .tx_addr(tx_addr), .hi_dyn_addr(hi_addr), .scl_i(scl), .sda_i(sda_bus),
      .sda_o(sda_o), .sda_pp(sda_pp), .arb_lost(lost), .arb_won(won)
   );

   // {tx, hi_dyn, rival (7F = none), lost bit (7 = none), switch count (0 = none)}
   localparam int NV = 12;
   localparam logic [26:0] VEC [NV] = '{
      {7'h7E, 7'h3F, 7'h7F, 3'd7, 3'd1},
      {7'h7E, 7'h5A, 7'h7F, 3'd7, 3'd2},
      {7'h7E, 7'h6F, 7'h7F, 3'd7, 3'd3},
      {7'h7E, 7'h7D, 7'h7F, 3'd7, 3'd6},
      {7'h7E, 7'h7E, 7'h7F, 3'd7, 3'd0},
      {7'h7E, 7'h3F, 7'h2A, 3'd0, 3'd1},
      {7'h7E, 7'h77, 7'h75, 3'd3, 3'd4},
      {7'h2A, 7'h10, 7'h2B, 3'd7, 3'd0},
      {7'h35, 7'h7F, 7'h33, 3'd4, 3'd0},
      {7'h00, 7'h00, 7'h7F, 3'd7, 3'd0},
      {7'h7F, 7'h20, 7'h7E, 3'd6, 3'd0},
      {7'h7E, 7'h00, 7'h7F, 3'd7, 3'd1}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic start_txn(input logic [6:0] tx, input logic [6:0] hi, input bit contested);
      @(negedge clk);
      tx_addr = tx; hi_addr = hi; scl = 1'b1; rival_drv = 1'b1;
      if (contested) txn_start = 1'b1; else rstart = 1'b1;
      @(negedge clk);
      txn_start = 1'b0; rstart = 1'b0;
      check(sda_o == 1'b0, "R2 start hold", sda_o, 0);
      check(sda_pp == 1'b0, "R6 pp at start", sda_pp, 0);
   endtask

   task automatic run_bits(input logic [6:0] tx, input logic [6:0] rival,
                           input logic [2:0] lost_bit, input logic [2:0] k);
      bit m_lost = 1'b0;
      bit r_act  = (rival != 7'h7F);
      for (int i = 0; i < 7; i++) begin
         bit exp_sda, exp_pp, exp_l, exp_w;
         @(negedge clk);
         scl = 1'b0;
         rival_drv = r_act ? rival[6-i] : 1'b1;
         @(negedge clk);
         check(!lost && !won, "R3 pulse width", lost + won, 0);
         exp_sda = m_lost ? 1'b1 : tx[6-i];
         check(sda_o == exp_sda, m_lost ? "R4 released" : "R2 bit order", sda_o, exp_sda);
         exp_pp = !m_lost && (k != 0) && (i >= int'(k));
         check(sda_pp == exp_pp, (k == 0) ? "R7 open-drain" : "R6 switch point", sda_pp, exp_pp);
         @(negedge clk);
         scl = 1'b1;
         if (r_act && rival[6-i] && !sda_bus) r_act = 1'b0;
         @(negedge clk);
         exp_l = !m_lost && (int'(lost_bit) == i);
         exp_w = !m_lost && (lost_bit == 3'd7) && (i == 6);
         check(lost == exp_l, "R3 lost pulse", lost, exp_l);
         check(won == exp_w, "R5 won pulse", won, exp_w);
         check(!(lost && won), "R10 exclusive", lost + won, 1);
         if (exp_l) m_lost = 1'b1;
      end
      @(negedge clk);
      scl = 1'b0; rival_drv = 1'b1;
      @(negedge clk);
      check(sda_o == 1'b1, "R5 release", sda_o, 1);
      check(sda_pp == 1'b0, "R5 pp off", sda_pp, 0);
      check(!lost && !won, "R4 no late pulse", lost + won, 0);
      @(negedge clk);
      scl = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [26:0] e;
      repeat (3) @(negedge clk);
      check(sda_o == 1'b1, "R1 sda reset", sda_o, 1);
      check(sda_pp == 1'b0, "R1 pp reset", sda_pp, 0);
      check(!lost && !won, "R1 flags reset", lost + won, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(sda_o == 1'b1 && !sda_pp, "R1 after release", sda_o, 1);

      for (int v = 0; v < NV; v++) begin
         e = VEC[v];
         start_txn(e[26:20], e[19:13], 1'b1);
         run_bits(e[26:20], e[12:6], e[5:3], e[2:0]);
      end

      // R9: inputs changed right after the start pulse are not used
      start_txn(7'h7E, 7'h3F, 1'b1);
      tx_addr = 7'h00; hi_addr = 7'h7F;
      run_bits(7'h7E, 7'h7F, 3'd7, 3'd1);

      // R4: loss, then repeated START ignored, then new START recovers
      start_txn(7'h7E, 7'h3F, 1'b1);
      run_bits(7'h7E, 7'h2A, 3'd0, 3'd1);
      @(negedge clk); rstart = 1'b1;
      @(negedge clk); rstart = 1'b0;
      check(sda_o == 1'b1, "R4 rstart ignored", sda_o, 1);
      @(negedge clk); scl = 1'b0;
      @(negedge clk);
      check(sda_o == 1'b1 && !sda_pp, "R4 still released", sda_o, 1);
      @(negedge clk); scl = 1'b1;
      @(negedge clk);
      check(!lost && !won, "R4 no pulse", lost + won, 0);
      start_txn(7'h7E, 7'h5A, 1'b1);
      run_bits(7'h7E, 7'h7F, 3'd7, 3'd2);

      // R8: uncontested address with the bus held low never loses
      start_txn(7'h7F, 7'h10, 1'b0);
      run_bits(7'h7F, 7'h00, 3'd7, 3'd0);
      // R8: switch rule still applies after repeated START
      start_txn(7'h7E, 7'h3F, 1'b0);
      run_bits(7'h7E, 7'h7F, 3'd7, 3'd1);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule